// File: doc/BRIEF.md
# Indirect Buffer Segment Fetcher

This block sits between a queue of packed 64-bit segment descriptors and a downstream command decoder. Each descriptor names a run of 32-bit command words in memory: a byte start address, a length in words and a flag that marks the run as a side (non-main) segment. The block turns each descriptor into a read window bounded by a read pointer (get) and an end pointer (put). It fetches the words one at a time through a request/response memory port and passes each word downstream on a valid/ready stream.

Descriptors enter through a small internal queue with a valid/ready handshake. A descriptor is taken from the queue only once the current window has been fully read. Besides get and put, the block keeps a saved main-stream read pointer. This pointer follows get word by word, but only while the active segment is a main segment. Each descriptor carries a list-end tag, and a one-cycle pulse reports that the last descriptor of a submitted list has been loaded. When the window is drained, the queue is empty and no word is still in flight, the block reports that it is idle.

Top module: `seg_fetch`

## Requirements
- R1: A descriptor is decoded as: bits 39:0 the byte start address, bit 41 the non-main flag, bits 62:42 the length in 32-bit words. Loading it sets get to the address, put to the address plus four times the length (modulo 2^40), and non_main to the flag. Bits 40 and 63 have no effect.
- R2: A descriptor is taken from the queue only while get equals put and no read or output word is in progress. put does not change while get differs from put.
- R3: Each read request carries the current get address. Each read response advances get by exactly 4 bytes.
- R4: After each returned word, main_get takes the new get value when non_main is 0. It keeps its value while non_main is 1.
- R5: At most one read is outstanding. No new request is made until the previous word has been accepted downstream.
- R6: word_data equals the returned memory word. While word_valid is high and word_ready is low, word_valid stays high and word_data stays stable.
- R7: A zero-length descriptor issues no read. The next queued descriptor is loaded on the following cycle.
- R8: idle is high exactly when the queue is empty, get equals put, and no read or output word is in flight. It is never high together with rd_req_valid or word_valid.
- R9: Descriptors are consumed and their words delivered in the order of acceptance. ent_ready is low when the queue holds FIFO_DEPTH descriptors. list_done pulses for one cycle after a descriptor tagged with ent_last is loaded.
- R10: After reset, get, put and main_get are 0, non_main is 0, idle is 1, and neither rd_req_valid nor word_valid is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | 1 | Descriptor offered |
| ent_ready | output | 1 | Queue has room for a descriptor |
| ent_data | input | 64 | Packed segment descriptor |
| ent_last | input | 1 | Descriptor is the last of its list |
| rd_req_valid | output | 1 | Word read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 40 | Byte address of the word to read |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 32 | Returned word |
| word_valid | output | 1 | Command word available downstream |
| word_ready | input | 1 | Decoder accepts the word |
| word_data | output | 32 | Command word |
| get_addr | output | 40 | Current read pointer |
| put_addr | output | 40 | End of current window |
| main_get | output | 40 | Saved main-stream read pointer |
| non_main | output | 1 | Active segment is non-main |
| list_done | output | 1 | Last descriptor of a list was loaded |
| idle | output | 1 | No work pending |

## Verification
The bench aims at the following corner cases, and at what a faulty design would do in each.

- Ignored bits: descriptors carry set ignored bits 40 and 63. A design that misread the packed fields would load a shifted length or a wrong flag.
- Zero-length descriptors: these are queued back to back. A design that did not skip them would stall or issue a spurious read to the empty segment's address.
- Address wrap: a segment wraps past the top of the 40-bit space. A design that widened or saturated put would then never see get equal put.
- Non-main segment: main_get is compared on every accepted word. A design that updated main_get regardless of the flag would move it inside a non-main segment.
- Random stalls: random memory and decoder stalls test that only one read is ever outstanding and that a held word stays stable.
- Full queue: filling the queue checks that ent_ready drops when it is full.

// File: rtl/seg_fetch.sv
module seg_fetch #(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ent_valid,
  output logic        ent_ready,
  input  logic [63:0] ent_data,
  input  logic        ent_last,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [39:0] rd_req_addr,
  input  logic        rd_rsp_valid,
  input  logic [31:0] rd_rsp_data,
  output logic        word_valid,
  input  logic        word_ready,
  output logic [31:0] word_data,
  output logic [39:0] get_addr,
  output logic [39:0] put_addr,
  output logic [39:0] main_get,
  output logic        non_main,
  output logic        list_done,
  output logic        idle
);
  localparam int ADDR_W = 40;
  localparam int LEN_W  = 21;
  localparam int SLOT_W = ADDR_W + LEN_W + 2;
  localparam int PTR_W  = $clog2(FIFO_DEPTH);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

  typedef enum logic [1:0] {S_RUN, S_WAIT, S_OUT} state_t;

  logic [SLOT_W-1:0] slot_mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  state_t            state;
  logic [ADDR_W-1:0] get_q, put_q, mget_q;
  logic              nm_q, done_q;
  logic [31:0]       word_q;

  logic              unused_bits;
  assign unused_bits = ent_data[63] ^ ent_data[40];

  logic [SLOT_W-1:0] head;
  logic [ADDR_W-1:0] head_addr;
  logic [LEN_W-1:0]  head_len;
  logic              head_nm, head_last;
  assign head = slot_mem[rd_ptr];
  assign {head_last, head_len, head_nm, head_addr} = head;

  logic push, load, drained;
  assign ent_ready = cnt != CNT_W'(FIFO_DEPTH);
  assign push      = ent_valid && ent_ready;
  assign drained   = get_q == put_q;
  assign load      = state == S_RUN && drained && cnt != '0;

  assign rd_req_valid = state == S_RUN && !drained;
  assign rd_req_addr  = get_q;
  assign word_valid   = state == S_OUT;
  assign word_data    = word_q;
  assign get_addr     = get_q;
  assign put_addr     = put_q;
  assign main_get     = mget_q;
  assign non_main     = nm_q;
  assign list_done    = done_q;
  assign idle         = state == S_RUN && drained && cnt == '0;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slot_mem[wr_ptr] <= {ent_last, ent_data[62:42], ent_data[41], ent_data[39:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (load) rd_ptr <= bump(rd_ptr);
      if (push && !load)      cnt <= cnt + 1'b1;
      else if (load && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_RUN;
      get_q  <= '0;
      put_q  <= '0;
      mget_q <= '0;
      nm_q   <= 1'b0;
      done_q <= 1'b0;
      word_q <= '0;
    end else begin
      done_q <= load && head_last;
      case (state)
        S_RUN: begin
          if (load) begin
            get_q <= head_addr;
            put_q <= head_addr + ADDR_W'({head_len, 2'b00});
            nm_q  <= head_nm;
          end else if (rd_req_valid && rd_req_ready) begin
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (rd_rsp_valid) begin
            word_q <= rd_rsp_data;
            get_q  <= get_q + ADDR_W'(4);
            if (!nm_q) mget_q <= get_q + ADDR_W'(4);
            state  <= S_OUT;
          end
        end
        S_OUT: begin
          if (word_ready) state <= S_RUN;
        end
        default: state <= S_RUN;
      endcase
    end
  end

  assert_put_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (get_q != put_q) |=> $stable(put_q));

  assert_get_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && rd_rsp_valid) |=> get_q == $past(get_q) + ADDR_W'(4));

  assert_main_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nm_q |=> $stable(mget_q));

  assert_one_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid);

  assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> word_valid && $stable(word_data));

  assert_zero_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && head_len == '0) |=> !rd_req_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !rd_req_valid && !word_valid);
endmodule

// File: tb/tb_seg_fetch.sv
module tb_seg_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ent_valid = 1'b0, ent_last = 1'b0;
  logic [63:0] ent_data = '0;
  logic        ent_ready;
  logic        rd_req_valid, rd_req_ready = 1'b0;
  logic [39:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        word_valid, word_ready = 1'b0;
  logic [31:0] word_data;
  logic [39:0] get_addr, put_addr, main_get;
  logic        non_main, list_done, idle;

  always #10 clk = ~clk;

  seg_fetch #(.FIFO_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_ready(ent_ready),
    .ent_data(ent_data), .ent_last(ent_last), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .get_addr(get_addr), .put_addr(put_addr), .main_get(main_get),
    .non_main(non_main), .list_done(list_done), .idle(idle));

  int n_chk = 0, n_bad = 0;
  logic [39:0] exp_addr [0:4095];
  bit          exp_nm   [0:4095];
  int tail = 0, rq_idx = 0, ac_idx = 0, n_last = 0, n_done = 0;
  logic [39:0] m_exp = '0, last_put = '0;
  bit hold_req = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [39:0] a);
    return (a[31:0] * 32'h9E3779B1) ^ {24'h0, a[39:32]};
  endfunction

  task automatic push(input logic [39:0] a, input int len, input bit nm,
                      input bit last, input bit junk);
    for (int i = 0; i < len; i++) begin
      exp_addr[tail] = a + 40'(4 * i);
      exp_nm[tail]   = nm;
      tail++;
    end
    if (last) n_last++;
    last_put = a + 40'(4 * len);
    @(negedge clk);
    ent_valid = 1'b1;
    ent_data  = {junk, 21'(len), nm, junk, a};
    ent_last  = last;
    while (!ent_ready) @(negedge clk);
    @(negedge clk);
    ent_valid = 1'b0;
  endtask

  task automatic drain();
    while (!(idle && ac_idx == tail && ent_valid == 1'b0)) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // memory responder
  bit          rsp_pend = 1'b0;
  int          dly = 0;
  logic [39:0] pend_a = '0;
  initial forever begin
    @(negedge clk);
    if (rsp_pend && dly == 0) begin
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = mem_word(pend_a);
      rsp_pend     = 1'b0;
    end else begin
      rd_rsp_valid = 1'b0;
      if (rsp_pend) dly--;
    end
    if (rsp_pend || rd_rsp_valid || word_valid)
      chk(!rd_req_valid, "R5", "request while busy", rd_req_valid, 0);
    rd_req_ready = hold_req ? 1'b0 : ($urandom % 4 != 0);
    if (rd_req_valid && rd_req_ready) begin
      chk(rd_req_addr == exp_addr[rq_idx], "R3", "request address", rd_req_addr, exp_addr[rq_idx]);
      rq_idx++;
      pend_a   = rd_req_addr;
      rsp_pend = 1'b1;
      dly      = $urandom % 3;
    end
  end

  // downstream consumer
  bit          prev_hold = 1'b0;
  logic [31:0] prev_data = '0;
  initial forever begin
    @(negedge clk);
    if (prev_hold)
      chk(word_valid && word_data == prev_data, "R6", "held word", word_data, prev_data);
    word_ready = ($urandom % 3 != 0);
    prev_hold  = word_valid && !word_ready;
    prev_data  = word_data;
    if (word_valid && word_ready) begin
      logic [39:0] a;
      a = exp_addr[ac_idx];
      chk(word_data == mem_word(a), "R9", "word order/data", word_data, mem_word(a));
      if (!exp_nm[ac_idx]) m_exp = a + 40'd4;
      chk(main_get == m_exp, "R4", "main_get", main_get, m_exp);
      chk(get_addr == a + 40'd4, "R3", "get after word", get_addr, a + 40'd4);
      ac_idx++;
    end
    if (list_done) n_done++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", ac_idx, tail);
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle == 1'b1, "R10", "idle", idle, 1);
    chk(get_addr == 0 && put_addr == 0, "R10", "get/put", get_addr, 0);
    chk(main_get == 0, "R10", "main_get", main_get, 0);
    chk(!rd_req_valid && !word_valid && !non_main, "R10", "req/word/nm",
        {rd_req_valid, word_valid, non_main}, 0);

    // R1: field decode with ignored bits set, non-main segment
    push(40'h12_3456_7890, 3, 1'b1, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk(get_addr == 40'h12_3456_7890, "R1", "get load", get_addr, 40'h12_3456_7890);
    chk(put_addr == 40'h12_3456_789C, "R1", "put load", put_addr, 40'h12_3456_789C);
    chk(non_main == 1'b1, "R1", "non_main flag", non_main, 1);
    chk(rd_req_addr == 40'h12_3456_7890 && !idle, "R8", "busy not idle", idle, 0);
    hold_req = 1'b0;
    drain();
    chk(main_get == 0, "R4", "main_get after non-main segment", main_get, 0);
    chk(get_addr == put_addr, "R2", "window drained", get_addr, put_addr);

    // R7: zero-length descriptors skipped without reads
    hold_req = 1'b1;
    push(40'h00_0000_1000, 0, 1'b0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk(idle && !rd_req_valid, "R7", "zero-length idle", idle, 1);
    chk(get_addr == 40'h1000 && put_addr == 40'h1000, "R7", "zero-length window", put_addr, 40'h1000);
    push(40'h00_0000_1800, 0, 1'b0, 1'b0, 1'b0);
    push(40'h00_0000_2000, 2, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(get_addr == 40'h2000 && rd_req_valid, "R7", "skip to next", get_addr, 40'h2000);
    chk(put_addr == 40'h2008, "R1", "put after skip", put_addr, 40'h2008);
    hold_req = 1'b0;
    drain();
    chk(main_get == 40'h2008, "R4", "main_get main segment", main_get, 40'h2008);

    // R1: 40-bit wrap of put
    push(40'hFF_FFFF_FFF8, 4, 1'b0, 1'b1, 1'b1);
    drain();
    chk(get_addr == 40'h8 && put_addr == 40'h8, "R1", "wrapped window", get_addr, 40'h8);
    chk(main_get == 40'h8, "R4", "wrapped main_get", main_get, 40'h8);

    // R9: queue fills and back-pressures
    hold_req = 1'b1;
    for (int i = 0; i < 5; i++) push(40'h40_0000_0000 + 40'(i * 64), 1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk(ent_ready == 1'b0, "R9", "full queue", ent_ready, 0);
    hold_req = 1'b0;
    drain();

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [39:0] a;
      a = {8'($urandom), 32'($urandom)} & ~40'h3;
      push(a, $urandom % 13, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    drain();
    repeat (2) @(negedge clk);
    chk(n_done == n_last, "R9", "list_done pulses", n_done, n_last);
    chk(get_addr == last_put && put_addr == last_put, "R2", "final window", get_addr, last_put);
    chk(idle == 1'b1, "R8", "final idle", idle, 1);
    chk(ac_idx == tail, "R9", "all words delivered", ac_idx, tail);
    finish_up();
  end
endmodule